// File: doc/BRIEF.md
# PTP Event Timestamp Record Queue

The block collects precision-time-protocol event timestamps as complete records and holds them in a queue until a host drains them over a simple register port. Each capture strobe stores one record made of a message tag, a 48-bit seconds value, a 32-bit nanoseconds value, a 64-bit source clock identity, a 16-bit source port number and a 16-bit sequence id. Upstream logic extracts these fields from the packet and the time counter.

The host sees two registers. The control/status register carries the capture enable, the position of the next word inside the current record, and a saturating count of events that could not be stored. The data register returns one 16-bit word of the oldest record per read. It steps through the record on its own and releases the record after its last word. A level output tells the host that at least one unread record is waiting. The host polls this output before it starts each readout. The tag's low three bits carry the event type (1 sync, 2 peer delay request, 3 peer delay response, 4 delay request). The block stores the tag and returns it unchanged.

Top module: `ptp_ts_record_fifo`

## Requirements
- R1: A record reads out as 12 data-register reads, each word in bits 15:0 with bits 31:16 zero, in this order: tag, seconds bits 47:32, 31:16, 15:0, nanoseconds bits 31:16, 15:0, clock identity bits 63:48, 47:32, 31:16, 15:0, port number, sequence id.
- R2: Status bits 12:8 hold the in-record word index (0 to 11) of the next data read. It is 0 when the next read returns the tag, and each data read of a non-empty queue increments it.
- R3: The 12th data read releases the record and returns the index to 0. The next record, if there is one, then reads out from its tag.
- R4: Status bit 15 is a read/write capture enable that resets to 0. While it is 0, a capture strobe stores nothing.
- R5: Status bits 7:4 count captures that were refused because the enable was 0 or the queue already held DEPTH records. The count saturates at 15.
- R6: Any write to the status register (address 0) clears the refused-event count and loads the enable from write-data bit 15.
- R7: The queue holds DEPTH (default 90) records and returns them in capture order.
- R8: not_empty rises in the cycle after an accepted capture and stays high while any unread record remains. It falls in the cycle after the final word of the last record is read.
- R9: A data read (address 1) of an empty queue returns 0 and leaves the word index at 0.
- R10: A capture accepted in the same cycle as a record-releasing 12th read is stored while the released record is removed, and no record is lost.
- R11: After reset, not_empty is 0 and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Capture strobe, one record per cycle |
| cap_tag | input | 16 | Message tag, low 3 bits give event type |
| cap_sec | input | 48 | Seconds |
| cap_nsec | input | 32 | Nanoseconds |
| cap_clkid | input | 64 | Source clock identity |
| cap_port | input | 16 | Source port number |
| cap_seq | input | 16 | Sequence id |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 status, 1 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| not_empty | output | 1 | At least one unread record |

## Verification
The two functions that can fall in the same cycle are a capture and the 12th word read that releases a record. The directed case queues two records and reads eleven words of the first. It then pulses the capture strobe together with the final read. The case passes when exactly the second and the new record drain afterwards, word for word, and not_empty then falls. The random phase raises further coincidences between captures and reads against the bench's own queue and status model. A fill past DEPTH checks the refused count and its saturation.

// File: rtl/ptp_tsfifo_pkg.sv
package ptp_tsfifo_pkg;
  localparam int WORD_W    = 16;
  localparam int REC_WORDS = 12;
  localparam int REC_W     = WORD_W * REC_WORDS;

  // field order matches readout order, first field in the top bits
  typedef struct packed {
    logic [15:0] tag;
    logic [47:0] sec;
    logic [31:0] nsec;
    logic [63:0] clkid;
    logic [15:0] portnum;
    logic [15:0] seqid;
  } ts_rec_t;

  function automatic logic [WORD_W-1:0] rec_word(ts_rec_t r, int idx);
    logic [REC_W-1:0] flat;
    flat = r;
    return flat[REC_W-1-WORD_W*idx -: WORD_W];
  endfunction
endpackage

// File: rtl/ts_rec_store.sv
module ts_rec_store
  import ptp_tsfifo_pkg::*;
#(
  parameter int DEPTH = 90
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  ts_rec_t                     rec_in,
  input  logic                        pop,
  output ts_rec_t                     rec_out,
  output logic [$clog2(DEPTH+1)-1:0]  occ
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  ts_rec_t mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [OCC_W-1:0] occ_q, occ_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    occ_d    = occ_q;
    if (push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({push, pop})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= rec_in;
  end

  assign rec_out = mem[rd_ptr_q];
  assign occ     = occ_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OCC_W'(DEPTH) && !pop) |-> !push);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ_q != '0));
  assert_occ_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(occ_q));
endmodule

// File: rtl/ts_word_seq.sv
module ts_word_seq #(
  parameter int WORDS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  output logic [$clog2(WORDS)-1:0]   pos,
  output logic                       last
);
  localparam int POS_W = $clog2(WORDS);
  localparam logic [POS_W-1:0] FINAL = POS_W'(WORDS-1);

  logic [POS_W-1:0] pos_q, pos_d;

  assign last = adv && (pos_q == FINAL);

  always_comb begin
    pos_d = pos_q;
    if (adv) pos_d = last ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= FINAL);
  assert_pos_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (pos_q == '0));
endmodule

// File: rtl/ts_drop_ctr.sv
module ts_drop_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_drop_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc && !clr) |=> (cnt_q == CNT_MAX));
  assert_drop_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/ptp_ts_record_fifo.sv
module ptp_ts_record_fifo
  import ptp_tsfifo_pkg::*;
#(
  parameter int DEPTH  = 90,
  parameter int DROP_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_valid,
  input  logic [15:0] cap_tag,
  input  logic [47:0] cap_sec,
  input  logic [31:0] cap_nsec,
  input  logic [63:0] cap_clkid,
  input  logic [15:0] cap_port,
  input  logic [15:0] cap_seq,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        not_empty
);
  localparam int   OCC_W       = $clog2(DEPTH+1);
  localparam int   POS_W       = $clog2(REC_WORDS);
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_DATA   = 1'b1;

  logic              en_q, en_d;
  logic [OCC_W-1:0]  occ;
  logic [POS_W-1:0]  pos;
  logic [DROP_W-1:0] drop_cnt;
  logic              full, has_rec, push, adv, pop, refuse, stat_wr;
  ts_rec_t           rec_in, rec_out;
  logic [31:0]       status_w;
  logic              unused_wdata;

  assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[14:0]};

  assign rec_in = '{tag: cap_tag, sec: cap_sec, nsec: cap_nsec,
                    clkid: cap_clkid, portnum: cap_port, seqid: cap_seq};

  assign full    = (occ == OCC_W'(DEPTH));
  assign has_rec = (occ != '0);
  assign push    = cap_valid && en_q && !full;
  assign refuse  = cap_valid && (!en_q || full);
  assign adv     = reg_rd && (reg_addr == ADDR_DATA) && has_rec;
  assign stat_wr = reg_wr && (reg_addr == ADDR_STATUS);

  always_comb begin
    en_d = en_q;
    if (stat_wr) en_d = reg_wdata[15];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  ts_rec_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .rec_in(rec_in),
    .pop(pop), .rec_out(rec_out), .occ(occ)
  );

  ts_word_seq #(.WORDS(REC_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .pos(pos), .last(pop)
  );

  ts_drop_ctr #(.CNT_W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .inc(refuse), .clr(stat_wr), .cnt(drop_cnt)
  );

  always_comb begin
    status_w        = '0;
    status_w[15]    = en_q;
    status_w[12:8]  = 5'(pos);
    status_w[7:4]   = 4'(drop_cnt);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_STATUS) reg_rdata = status_w;
      else if (has_rec)            reg_rdata = {16'h0, rec_word(rec_out, int'(pos))};
    end
  end

  assign not_empty = has_rec;

  assert_ne_after_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> not_empty);
  assert_disabled_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !not_empty && !stat_wr) |=> !not_empty);
endmodule

// File: tb/test_ptp_ts_record_fifo.sv
module test_ptp_ts_record_fifo;
  localparam int DEPTH = 90;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cap_valid, reg_rd, reg_wr, reg_addr;
  logic [15:0] cap_tag, cap_port, cap_seq;
  logic [47:0] cap_sec;
  logic [31:0] cap_nsec, reg_wdata, reg_rdata;
  logic [63:0] cap_clkid;
  logic        not_empty;

  ptp_ts_record_fifo #(.DEPTH(DEPTH)) i_ptp_ts_record_fifo (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_tag(cap_tag),
    .cap_sec(cap_sec), .cap_nsec(cap_nsec), .cap_clkid(cap_clkid),
    .cap_port(cap_port), .cap_seq(cap_seq), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .not_empty(not_empty)
  );

  int n_tests = 0, n_fail = 0;
  logic [191:0] model [0:255];
  int head = 0, tail = 0;
  logic en_m = 1'b0;
  int drop_m = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [191:0] mk_rec();
    logic [191:0] v;
    v = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    v[178:176] = 3'($urandom_range(1, 4));
    return v;
  endfunction

  function automatic logic [31:0] exp_status(int idx);
    logic [31:0] s;
    s = '0;
    s[15] = en_m;
    s[12:8] = 5'(idx);
    s[7:4] = 4'(drop_m);
    return s;
  endfunction

  function automatic void model_cap(logic [191:0] v);
    if (!en_m || (tail - head) >= DEPTH) begin
      if (drop_m < 15) drop_m++;
    end else begin
      model[tail % 256] = v;
      tail++;
    end
  endfunction

  task automatic set_cap(logic [191:0] v);
    cap_valid = 1'b1;
    cap_tag = v[191:176]; cap_sec = v[175:128]; cap_nsec = v[127:96];
    cap_clkid = v[95:32]; cap_port = v[31:16]; cap_seq = v[15:0];
  endtask

  task automatic capture(logic [191:0] v);
    set_cap(v);
    model_cap(v);
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic rd(logic a, output logic [31:0] d, input logic with_cap, input logic [191:0] v);
    reg_rd = 1'b1; reg_addr = a;
    if (with_cap) set_cap(v);
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; cap_valid = 1'b0;
  endtask

  task automatic wr_status(logic [31:0] w);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = w;
    en_m = w[15]; drop_m = 0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_record(logic with_cap, logic [191:0] cv);
    logic [31:0] d;
    logic [191:0] e;
    e = model[head % 256];
    for (int i = 0; i < 12; i++) begin
      rd(1'b0, d, 1'b0, '0);
      chk("R2", "word index", d, exp_status(i));
      if (i == 11 && with_cap) begin
        rd(1'b1, d, 1'b1, cv);
        model_cap(cv);
      end else begin
        rd(1'b1, d, 1'b0, '0);
      end
      chk("R1", "data word", d, {16'h0, e[191-16*i -: 16]});
    end
    head++;
    rd(1'b0, d, 1'b0, '0);
    chk("R3", "index after release", d, exp_status(0));
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cap_valid = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0;
    reg_wdata = '0; cap_tag = '0; cap_sec = '0; cap_nsec = '0; cap_clkid = '0;
    cap_port = '0; cap_seq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R11", "not_empty after reset", 32'(not_empty), 32'd0);
    rd(1'b0, d, 1'b0, '0);
    chk("R11", "status after reset", d, 32'h0);

    capture(mk_rec());
    chk("R4", "not_empty while disabled", 32'(not_empty), 32'd0);
    rd(1'b0, d, 1'b0, '0);
    chk("R5", "refused count while disabled", d, 32'h0000_0010);

    wr_status(32'h0000_8000);
    rd(1'b0, d, 1'b0, '0);
    chk("R6", "status after write", d, 32'h0000_8000);

    rd(1'b1, d, 1'b0, '0);
    chk("R9", "empty data read", d, 32'h0);
    rd(1'b0, d, 1'b0, '0);
    chk("R9", "index after empty read", d, exp_status(0));

    for (int r = 0; r < 8; r++) begin
      int k = $urandom_range(1, 4);
      for (int j = 0; j < k; j++) begin
        capture(mk_rec());
        chk("R8", "not_empty after capture", 32'(not_empty), 32'd1);
      end
      while (head != tail) begin
        read_record(1'b0, '0);
        chk("R8", "not_empty vs model", 32'(not_empty), 32'(head != tail));
      end
    end

    capture(mk_rec());
    capture(mk_rec());
    read_record(1'b1, mk_rec());
    chk("R10", "not_empty after coincident capture", 32'(not_empty), 32'd1);
    chk("R10", "model occupancy", 32'(tail - head), 32'd2);
    read_record(1'b0, '0);
    read_record(1'b0, '0);
    chk("R10", "not_empty after draining", 32'(not_empty), 32'd0);

    wr_status(32'h0000_8000);
    for (int j = 0; j < DEPTH + 20; j++) capture(mk_rec());
    rd(1'b0, d, 1'b0, '0);
    chk("R5", "saturated refused count when full", d, 32'h0000_80F0);
    chk("R7", "model holds DEPTH", 32'(tail - head), 32'(DEPTH));
    for (int j = 0; j < DEPTH; j++) read_record(1'b0, '0);
    chk("R7", "not_empty after full drain", 32'(not_empty), 32'd0);

    wr_status(32'h0);
    capture(mk_rec());
    chk("R4", "not_empty after disable", 32'(not_empty), 32'd0);
    rd(1'b0, d, 1'b0, '0);
    chk("R4", "status after disabled capture", d, 32'h0000_0010);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule